// File: doc/BRIEF.md
# SDRAM command and refresh scheduler

This block sits between a simple request port and a two-bank SDR SDRAM with 11 row bits and 9 column bits. A client offers one read or write at a time on a valid/ready handshake with a flat address. The block splits that address into bank, row and column and opens the row with ACTIVATE. After the row-to-column delay it issues the column command with auto-precharge set, so every access closes its own row. The command is driven on chip-select, row strobe, column strobe and write enable, all registered, and NOP fills every cycle with no command due.

After reset the block waits, then runs a fixed start-up sequence: precharge all banks, two auto-refreshes, and a mode register load with burst length 1 and the configured CAS latency. It accepts no request until that sequence is over. From then on an interval counter raises a refresh request every `REF_INTERVAL` cycles. The default is 1562 cycles, about 15.6 us at 100 MHz, which gives 4096 refreshes in 64 ms. A pending refresh is served before any new request once the access in flight has finished. Read data is sampled from the data bus CAS latency cycles after the device samples the READ command, and it is returned on a one-cycle valid pulse.

Top module: `sdram_sched`

## Requirements
- R1: While reset is held and until the mode register load has been issued, `req_ready_o` is low and `rd_valid_o` is low. Only NOP is driven before the first start-up command, which comes no earlier than `T_INIT` cycles after reset. The start-up commands come in this order: PRECHARGE with address bit 10 high, REFRESH, REFRESH, MODE REGISTER SET.
- R2: The mode register load drives bank 0 and the address value CL*16. That value puts the CAS latency in address bits 6..4, a sequential burst type in bit 3 (0), and burst length 1 in bits 2..0 (000).
- R3: Request address bit 20 is the bank, bits 19..9 are the row and bits 8..0 are the column. ACTIVATE carries the bank and the row. The column command carries the same bank, the column in address bits 8..0, bit 9 low and bit 10 high for auto-precharge.
- R4: Commands are encoded as {cs_n, ras_n, cas_n, we_n}: NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, MODE REGISTER SET 0000. No other value is ever driven.
- R5: The column command follows its ACTIVATE after exactly `T_RCD` cycles.
- R6: An ACTIVATE or REFRESH comes at least `T_RC` cycles after the previous ACTIVATE or REFRESH. The first REFRESH comes at least `T_RP` cycles after the start-up PRECHARGE.
- R7: The data output enable is high only in the WRITE cycle, and the write data of the accepted request is then on `sd_dq_o`.
- R8: For each READ, `rd_valid_o` pulses for one cycle, CL+1 cycles after the READ appears on the command lines. `rd_data_o` then holds the value the device drove for that READ.
- R9: After start-up a REFRESH is issued every `REF_INTERVAL` cycles, with a spread of no more than `T_RC`+2 cycles. When a refresh is pending, a waiting request is held off and the REFRESH goes out first.
- R10: Each accepted request produces exactly one ACTIVATE and one column command, in the order the requests were accepted, and read data matches the data last written to that flat address (0 if the address was never written).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request accepted this cycle if valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 21 | Flat address {bank, row, column} |
| req_wdata_i | input | DW | Write data |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | DW | Read data |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_ba_o | output | 1 | Bank address |
| sd_addr_o | output | 11 | Row, column or mode address |
| sd_dq_o | output | DW | Write data to device |
| sd_dq_oe_o | output | 1 | Data output enable |
| sd_dq_i | input | DW | Read data from device |

## Verification
The two functions that meet in one cycle are the refresh request and a waiting client request: both become eligible on the cycle the scheduler returns to idle. The bench provokes this by keeping requests back to back, so that `req_valid_i` is nearly always high when the interval counter expires. When a REFRESH shows up on the command lines while `req_valid_i` is still high, the bench counts a collision. The REFRESH, rather than an ACTIVATE, proves that the refresh won. The bench then checks that the held request's ACTIVATE follows no sooner than `T_RC` later, that its data still round-trips, and that the gap between refreshes stays in bound.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    S_INIT_WAIT,
    S_PALL_W,
    S_REF1_W,
    S_REF2_W,
    S_IDLE,
    S_ACT_W,
    S_RECOV
  } sdr_state_e;
endpackage

// File: rtl/sdr_dcount.sv
module sdr_dcount #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= W'(RST_VAL);
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdr_ref_tmr.sv
module sdr_ref_tmr #(
  parameter int INTERVAL = 1562
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ack_i,
  output logic pend_o
);
  localparam int RW = $clog2(INTERVAL + 1);

  logic [RW-1:0] cnt_q;
  logic          wrap;

  assign wrap = en_i && (cnt_q == RW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      if (en_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      pend_o <= wrap | (pend_o & ~ack_i);
    end
  end

  // a pending refresh only drops when the scheduler takes it
  assert_pend_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_o) |-> $past(ack_i));
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
  parameter int CL = 2,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_cmd_i,
  input  logic [DW-1:0] dq_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  logic [CL-1:0] pipe_q;

  generate
    if (CL == 1) begin : g_cl1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= rd_cmd_i;
      end
    end else begin : g_cln
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[CL-2:0], rd_cmd_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= pipe_q[CL-1];
      if (pipe_q[CL-1]) data_o <= dq_i;
    end
  end

  assert_rd_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(rd_cmd_i, CL + 1));
endmodule

// File: rtl/sdram_sched.sv
module sdram_sched
  import sdr_pkg::*;
#(
  parameter int DW           = 16,
  parameter int BANK_W       = 1,
  parameter int ROW_W        = 11,
  parameter int COL_W        = 9,
  parameter int CL           = 2,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_RC         = 6,
  parameter int T_MRD        = 2,
  parameter int T_INIT       = 100,
  parameter int REF_INTERVAL = 1562
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic                          req_we_i,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr_i,
  input  logic [DW-1:0]                 req_wdata_i,
  output logic                          rd_valid_o,
  output logic [DW-1:0]                 rd_data_o,
  output logic                          sd_cs_n_o,
  output logic                          sd_ras_n_o,
  output logic                          sd_cas_n_o,
  output logic                          sd_we_n_o,
  output logic [BANK_W-1:0]             sd_ba_o,
  output logic [ROW_W-1:0]              sd_addr_o,
  output logic [DW-1:0]                 sd_dq_o,
  output logic                          sd_dq_oe_o,
  input  logic [DW-1:0]                 sd_dq_i
);
  localparam int AW     = BANK_W + ROW_W + COL_W;
  localparam int AP_BIT = 10;
  localparam int TW     = $clog2(T_INIT + T_RC + T_RP + T_MRD + 2) + 1;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CL * 16);

  sdr_state_e        state_q, state_d;
  sdr_cmd_e          cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_d;
  logic [ROW_W-1:0]  addr_d;
  logic              oe_q, oe_d;
  logic              init_q, init_d;
  logic              tmr_ld, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic              ref_pend, ref_ack, accept;

  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [DW-1:0]     wdata_q;

  sdr_dcount #(.W(TW), .RST_VAL(T_INIT - 1)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_ld),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sdr_ref_tmr #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (init_q),
    .ack_i  (ref_ack),
    .pend_o (ref_pend)
  );

  sdr_rd_capture #(.CL(CL), .DW(DW)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_cmd_i (cmd_q == CMD_RD),
    .dq_i     (sd_dq_i),
    .valid_o  (rd_valid_o),
    .data_o   (rd_data_o)
  );

  assign req_ready_o = (state_q == S_IDLE) && !ref_pend;
  assign accept      = req_ready_o && req_valid_i;

  always_comb begin
    state_d = state_q;
    cmd_d   = CMD_NOP;
    ba_d    = '0;
    addr_d  = '0;
    oe_d    = 1'b0;
    init_d  = init_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    ref_ack = 1'b0;
    unique case (state_q)
      S_INIT_WAIT: if (tmr_zero) begin
        cmd_d          = CMD_PRE;
        addr_d[AP_BIT] = 1'b1;
        tmr_ld         = 1'b1;
        tmr_val        = TW'(T_RP - 1);
        state_d        = S_PALL_W;
      end
      S_PALL_W: if (tmr_zero) begin
        cmd_d   = CMD_REF;
        tmr_ld  = 1'b1;
        tmr_val = TW'(T_RC - 1);
        state_d = S_REF1_W;
      end
      S_REF1_W: if (tmr_zero) begin
        cmd_d   = CMD_REF;
        tmr_ld  = 1'b1;
        tmr_val = TW'(T_RC - 1);
        state_d = S_REF2_W;
      end
      S_REF2_W: if (tmr_zero) begin
        cmd_d   = CMD_MRS;
        addr_d  = MODE_WORD;
        tmr_ld  = 1'b1;
        tmr_val = TW'(T_MRD - 1);
        init_d  = 1'b1;
        state_d = S_RECOV;
      end
      S_IDLE: begin
        if (ref_pend) begin
          cmd_d   = CMD_REF;
          ref_ack = 1'b1;
          tmr_ld  = 1'b1;
          tmr_val = TW'(T_RC - 1);
          state_d = S_RECOV;
        end else if (req_valid_i) begin
          cmd_d   = CMD_ACT;
          ba_d    = req_addr_i[AW-1 -: BANK_W];
          addr_d  = req_addr_i[COL_W +: ROW_W];
          tmr_ld  = 1'b1;
          tmr_val = TW'(T_RCD - 1);
          state_d = S_ACT_W;
        end
      end
      S_ACT_W: if (tmr_zero) begin
        cmd_d                = we_q ? CMD_WR : CMD_RD;
        ba_d                 = bank_q;
        addr_d[COL_W-1:0]    = col_q;
        addr_d[AP_BIT]       = 1'b1;
        oe_d                 = we_q;
        tmr_ld               = 1'b1;
        tmr_val              = TW'(T_RC - T_RCD - 1);
        state_d              = S_RECOV;
      end
      S_RECOV: if (tmr_zero) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_INIT_WAIT;
      cmd_q     <= CMD_NOP;
      sd_ba_o   <= '0;
      sd_addr_o <= '0;
      oe_q      <= 1'b0;
      init_q    <= 1'b0;
      bank_q    <= '0;
      row_q     <= '0;
      col_q     <= '0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
    end else begin
      state_q   <= state_d;
      cmd_q     <= cmd_d;
      sd_ba_o   <= ba_d;
      sd_addr_o <= addr_d;
      oe_q      <= oe_d;
      init_q    <= init_d;
      if (accept) begin
        bank_q  <= req_addr_i[AW-1 -: BANK_W];
        row_q   <= req_addr_i[COL_W +: ROW_W];
        col_q   <= req_addr_i[COL_W-1:0];
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd_q;
  assign sd_dq_o    = wdata_q;
  assign sd_dq_oe_o = oe_q;

  // cycles since the last ACTIVATE, for the tRCD check
  logic [TW-1:0] act_age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                act_age_q <= '1;
    else if (cmd_q == CMD_ACT)  act_age_q <= TW'(1);
    else if (act_age_q != '1)   act_age_q <= act_age_q + 1'b1;
  end

  assert_no_ready_in_init_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_q |-> !req_ready_o);
  assert_col_autopre_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> sd_addr_o[AP_BIT]);
  assert_trcd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> act_age_q == TW'(T_RCD));
  assert_oe_only_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_dq_oe_o |-> cmd_q == CMD_WR);
  assert_ref_blocks_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_pend && state_q == S_IDLE) |=> cmd_q == CMD_REF);
endmodule

// File: tb/sdram_sched_tb.sv
module sdram_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW      = 16;
  localparam int CL      = 2;
  localparam int T_RCD   = 2;
  localparam int T_RP    = 2;
  localparam int T_RC    = 6;
  localparam int T_MRD   = 2;
  localparam int T_INIT  = 20;
  localparam int REF_INT = 150;
  localparam logic [DW-1:0] FILL = 16'hA5A5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [20:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, cs_n, ras_n, cas_n, we_n, ba, dq_oe;
  logic [DW-1:0] rd_data, dq_o;
  logic [DW-1:0] dq_i = FILL;
  logic [10:0] addr;

  sdram_sched #(.DW(DW), .CL(CL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC),
                .T_MRD(T_MRD), .T_INIT(T_INIT), .REF_INTERVAL(REF_INT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n), .sd_cas_n_o(cas_n), .sd_we_n_o(we_n),
    .sd_ba_o(ba), .sd_addr_o(addr), .sd_dq_o(dq_o), .sd_dq_oe_o(dq_oe), .sd_dq_i(dq_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct { bit we; int bank; int row; int col; logic [DW-1:0] data; } req_t;
  req_t act_q[$];
  req_t cur;
  logic [DW-1:0] exp_d[$];
  int exp_cyc[$];
  int drv_cyc[$];
  logic [DW-1:0] drv_val[$];
  logic [DW-1:0] ref_mem[int];
  logic [DW-1:0] dram_mem[int];
  int open_row[2];

  int cyc = 0, init_idx = 0, init_end = 0;
  int last_act = -1000, last_ref = -1000, last_pre = -1000;
  bit ref_post = 1'b0;
  int ref_cnt = 0, collisions = 0;
  bit prev_rdv = 1'b0, first_ready_seen = 1'b0;

  // monitor, DRAM model and scoreboard
  always @(negedge clk) begin
    logic [3:0] cmd;
    int key;
    cyc++;
    if (drv_cyc.size() > 0 && drv_cyc[0] == cyc) begin
      dq_i = drv_val[0];
      void'(drv_cyc.pop_front());
      void'(drv_val.pop_front());
    end else dq_i = FILL;
    cmd = {cs_n, ras_n, cas_n, we_n};
    if (!rst_ni) begin
      chk(cmd == 4'b0111, "R1", "reset cmd", cmd, 4'b0111);
      chk(!req_ready && !rd_valid, "R1", "reset ready/rdv", {req_ready, rd_valid}, 0);
    end else begin
      if (req_ready && !first_ready_seen) begin
        first_ready_seen = 1'b1;
        chk(init_idx == 4, "R1", "ready before init done", init_idx, 4);
      end
      if (dq_oe) chk(cmd == 4'b0100, "R7", "oe outside write", cmd, 4'b0100);
      case (cmd)
        4'b0111: ;
        4'b0010: begin
          chk(init_idx == 0, "R1", "precharge order", init_idx, 0);
          chk(cyc - 1 >= T_INIT, "R1", "init wait", cyc - 1, T_INIT);
          chk(addr[10], "R1", "precharge all bit", addr[10], 1);
          last_pre = cyc;
          if (init_idx < 4) init_idx++;
        end
        4'b0001: begin
          if (init_idx == 1) begin
            chk(cyc - last_pre >= T_RP, "R6", "tRP", cyc - last_pre, T_RP);
            init_idx++;
          end else if (init_idx == 2) begin
            chk(cyc - last_ref >= T_RC, "R6", "init tRC", cyc - last_ref, T_RC);
            init_idx++;
          end else begin
            chk(init_idx == 4, "R1", "refresh order", init_idx, 4);
            chk(cyc - last_act >= T_RC, "R6", "act->ref", cyc - last_act, T_RC);
            chk(cyc - last_ref >= T_RC, "R6", "ref->ref", cyc - last_ref, T_RC);
            if (ref_post) begin
              chk(cyc - last_ref <= REF_INT + T_RC + 2, "R9", "ref gap max", cyc - last_ref, REF_INT + T_RC + 2);
              chk(cyc - last_ref >= REF_INT - T_RC - 2, "R9", "ref gap min", cyc - last_ref, REF_INT - T_RC - 2);
            end
            if (req_valid) collisions++;
            ref_post = 1'b1;
            ref_cnt++;
          end
          last_ref = cyc;
        end
        4'b0000: begin
          chk(init_idx == 3, "R1", "mode set order", init_idx, 3);
          chk(!req_ready, "R1", "ready at mode set", req_ready, 0);
          chk(cyc - last_ref >= T_RC, "R6", "ref->mrs", cyc - last_ref, T_RC);
          chk(addr == 11'(CL * 16), "R2", "mode word", addr, CL * 16);
          chk(ba == 1'b0, "R2", "mode bank", ba, 0);
          init_idx = 4;
          init_end = cyc;
        end
        4'b0011: begin
          chk(init_idx == 4, "R1", "act before init", init_idx, 4);
          chk(cyc - last_act >= T_RC, "R6", "act->act", cyc - last_act, T_RC);
          chk(cyc - last_ref >= T_RC, "R6", "ref->act", cyc - last_ref, T_RC);
          if (act_q.size() == 0) chk(0, "R10", "unexpected act", 0, 1);
          else begin
            cur = act_q.pop_front();
            chk(ba == cur.bank[0], "R3", "act bank", ba, cur.bank);
            chk(addr == cur.row[10:0], "R3", "act row", addr, cur.row);
          end
          open_row[ba] = int'(addr);
          last_act = cyc;
        end
        4'b0100, 4'b0101: begin
          chk(cyc - last_act == T_RCD, "R5", "tRCD", cyc - last_act, T_RCD);
          chk(ba == cur.bank[0], "R3", "col bank", ba, cur.bank);
          chk(addr[8:0] == cur.col[8:0], "R3", "col addr", addr[8:0], cur.col);
          chk(addr[10] && !addr[9], "R3", "autopre bits", addr[10:9], 2);
          chk(cmd[0] == !cur.we, "R10", "col kind", cmd, cur.we ? 4 : 5);
          key = (int'(ba) << 20) | (open_row[ba] << 9) | int'(addr[8:0]);
          if (cmd == 4'b0100) begin
            chk(dq_oe == 1'b1, "R7", "oe in write", dq_oe, 1);
            chk(dq_o == cur.data, "R7", "write data", dq_o, cur.data);
            dram_mem[key] = dq_o;
          end else begin
            drv_cyc.push_back(cyc + CL);
            drv_val.push_back(dram_mem.exists(key) ? dram_mem[key] : '0);
            exp_cyc.push_back(cyc + CL + 1);
          end
        end
        default: chk(0, "R4", "illegal command", cmd, 4'b0111);
      endcase
      if (rd_valid) begin
        chk(!prev_rdv, "R8", "valid pulse width", prev_rdv, 0);
        if (exp_d.size() == 0 || exp_cyc.size() == 0) chk(0, "R8", "unexpected read data", rd_data, 0);
        else begin
          chk(rd_data == exp_d[0], "R10", "read data", rd_data, exp_d[0]);
          chk(cyc == exp_cyc[0], "R8", "read latency", cyc, exp_cyc[0]);
          void'(exp_d.pop_front());
          void'(exp_cyc.pop_front());
        end
      end
      prev_rdv = rd_valid;
    end
  end

  // driver: holds valid until accepted, pushes expected items
  task automatic do_req(bit we, int a, logic [DW-1:0] d);
    req_t r;
    @(negedge clk); #1;
    req_we = we; req_addr = a[20:0]; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) begin @(negedge clk); #1; end
    r.we = we; r.bank = (a >> 20) & 1; r.row = (a >> 9) & 2047; r.col = a & 511; r.data = d;
    act_q.push_back(r);
    if (we) ref_mem[a] = d;
    else exp_d.push_back(ref_mem.exists(a) ? ref_mem[a] : '0);
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(0, "R1", "watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pool[8];
    int s;
    s = 32'h1234_5678;
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    // R3 corners: bank/row/column extremes
    do_req(1, 21'h000000, 16'h1111);
    do_req(1, 21'h1FFFFF, 16'h2222);
    do_req(1, 21'h100000, 16'h3333);
    do_req(1, 21'h0FFFFF, 16'h4444);
    do_req(1, 21'h0001FF, 16'h5555);
    do_req(0, 21'h1FFFFF, 0);
    do_req(0, 21'h000000, 0);
    do_req(0, 21'h0FFFFF, 0);
    do_req(0, 21'h100000, 0);
    do_req(0, 21'h0001FF, 0);
    do_req(1, 21'h000000, 16'h6666);
    do_req(0, 21'h000000, 0);
    do_req(0, 21'h0ABCDE, 0);          // never written: 0
    for (int i = 0; i < 8; i++) begin
      s = s * 1103515245 + 12345;
      pool[i] = (s >>> 7) & 21'h1FFFFF;
    end
    // back-to-back traffic to provoke refresh/request collisions (R9)
    for (int i = 0; i < 160; i++) begin
      s = s * 1103515245 + 12345;
      do_req(s[12], pool[(s >>> 16) & 7], 16'(s ^ i) | 16'h0001);
    end
    repeat (2 * REF_INT + 50) @(negedge clk);
    for (int i = 0; i < 8; i++) do_req(0, pool[i], 0);
    repeat (40) @(negedge clk);
    chk(init_idx == 4, "R1", "init completed", init_idx, 4);
    chk(act_q.size() == 0, "R10", "pending accesses", act_q.size(), 0);
    chk(exp_d.size() == 0, "R8", "missing read data", exp_d.size(), 0);
    chk(collisions > 0, "R9", "refresh won over waiting request", collisions, 1);
    chk(ref_cnt >= (cyc - init_end) / (REF_INT + T_RC + 2) - 1, "R9", "refresh count",
        ref_cnt, (cyc - init_end) / (REF_INT + T_RC + 2) - 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule